// File: doc/BRIEF.md
# E1 Receive CAS Signaling Extractor

This block sits behind an E1 receive framer that has already found frame and multiframe alignment. For every received byte the framer presents the byte itself, its timeslot number (0 to 31) and the frame number (0 to 15) within the 16-frame CAS multiframe. The block keeps only the timeslot 16 bytes. It gathers the sixteen of one multiframe in a working buffer. When the timeslot 16 byte of frame 15 arrives, it copies the whole set into sixteen signaling registers that a host can read. Host-visible signaling data therefore never changes partway through a multiframe.

Each copy sets a sticky new-data flag. The block also compares the channel signaling of the new set with the set copied before it. One shared status bit reports either that comparison or an external loss-of-transmit-clock indication, selected by a mode bit. Each of the two status bits has its own interrupt enable. Reading the status register clears the sticky flags. The interrupt output is the OR of the enabled status bits.

Top module: `e1_cas_extract`

## Requirements
- R1: Only bytes presented with rx_valid high and timeslot index 16 enter the signaling buffer; bytes in every other timeslot have no effect on the signaling registers.
- R2: Host address n (0 to 15) reads the timeslot 16 byte of frame n of the last committed multiframe. Address 0 holds the frame-0 byte (alignment nibble in bits 7..4, alarm/spare bits in bits 3..0). Address k (1 to 15) holds channel k ABCD in bits 7..4 (A in bit 7) and channel k+15 ABCD in bits 3..0.
- R3: The signaling registers change only on the cycle after the timeslot 16 byte of frame 15 is accepted; a partly received multiframe leaves them unchanged.
- R4: Every commit sets the new-data flag, status bit 0. It stays set until a host read of the status register (address 16); a commit in the same cycle as that read wins.
- R5: With the mode bit (control bit 0) at 1, status bit 1 reports a change of state: it is set at a commit when any of addresses 1 to 15 differs from the previous commit. A difference confined to address 0 does not set it. It is cleared by a status read.
- R6: The first commit after reset never sets the change-of-state flag.
- R7: With the mode bit at 0, status bit 1 reports loss of transmit clock: it is set in any cycle where tx_clk_lost is high and held until a status read.
- R8: irq equals (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2); an enable bit of 1 passes the interrupt, 0 masks it.
- R9: Synchronous active-low reset clears the signaling registers, the working buffer, all flags, the control register, host_rdata and irq.
- R10: Address 17 is the control register (written with host_wr, read back on bits 2..0). Reads return data on host_rdata one cycle after host_rd. Addresses 18 to 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte strobe from the framer |
| rx_byte | input | 8 | Received byte |
| rx_slot | input | 5 | Timeslot index of rx_byte |
| rx_frame | input | 4 | Frame index within the multiframe |
| tx_clk_lost | input | 1 | Loss-of-transmit-clock indication |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 3 | Host write data (control bits) |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the signaling bank holds still except at the frame-15 timeslot 16 byte;
- each commit sets the new-data flag, and a lone status read clears it;
- the first commit after reset reports no change;
- the control register moves only on writes;
- unmapped reads return zero;
- irq stays low when both enables are off;
- reset clears the outputs.

Only the directed scenarios can show the rest:
- the byte-to-address mapping and the rejection of non-16 timeslots;
- that an address-0-only difference is ignored while a channel difference is reported;
- the switch of the shared bit to loss of transmit clock.

// File: rtl/e1cas_pkg.sv
// Shared constants and types for the E1 receive CAS signaling extractor.
// Assumes a 32-slot E1 frame and a 16-frame CAS multiframe.
package e1cas_pkg;
    localparam int BYTE_W   = 8;
    localparam int SLOT_W   = 5;
    localparam int MF_LEN   = 16;
    localparam int FRAME_W  = $clog2(MF_LEN);
    localparam int SIG_SLOT = 16;
    localparam int ADDR_W   = 5;
    localparam int CTRL_W   = 3;
    localparam int ADDR_STATUS = MF_LEN;
    localparam int ADDR_CTRL   = MF_LEN + 1;

    // Control register: bit0 mode, bit1 new-data enable, bit2 shared-bit enable.
    typedef struct packed {
        logic sh_en;
        logic nd_en;
        logic cos_mode;
    } ctrl_t;
endpackage

// File: rtl/e1cas_collect.sv
// Collects timeslot 16 bytes into a working buffer and commits them to the
// host bank when frame 15's signaling byte arrives. Flags change of state
// (addresses 1..15 only) against the previous commit.
// Assumes the framer's slot and frame indices are already aligned.
module e1cas_collect
    import e1cas_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rx_valid,
    input  logic [BYTE_W-1:0]                 rx_byte,
    input  logic [SLOT_W-1:0]                 rx_slot,
    input  logic [FRAME_W-1:0]                rx_frame,
    output logic [MF_LEN-1:0][BYTE_W-1:0]     bank,
    output logic                              commit,
    output logic                              cos
);
    logic [MF_LEN-1:0][BYTE_W-1:0] work;
    logic [MF_LEN-1:0][BYTE_W-1:0] next_bank;
    logic [MF_LEN-1:0]             diff;
    logic                          primed;
    logic                          take;
    logic                          last;

    assign take = rx_valid && (rx_slot == SLOT_W'(SIG_SLOT));
    assign last = (rx_frame == FRAME_W'(MF_LEN - 1));

    // Image of the bank as it will be after this multiframe closes.
    always_comb begin
        next_bank              = work;
        next_bank[MF_LEN-1]    = rx_byte;
    end

    // Per-register compare; address 0 carries alignment/alarm bits, not channels.
    assign diff[0] = 1'b0;
    for (genvar i = 1; i < MF_LEN; i++) begin : g_cmp
        assign diff[i] = (next_bank[i] != bank[i]);
    end

    // Capture signaling bytes and commit at the multiframe boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work   <= '0;
            bank   <= '0;
            commit <= 1'b0;
            cos    <= 1'b0;
            primed <= 1'b0;
        end else begin
            commit <= 1'b0;
            cos    <= 1'b0;
            if (take) begin
                work[rx_frame] <= rx_byte;
                if (last) begin
                    bank   <= next_bank;
                    commit <= 1'b1;
                    cos    <= primed && (|diff);
                    primed <= 1'b1;
                end
            end
        end
    end

    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && last) |=> $stable(bank));
    p_first_no_cos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !primed) |=> (commit && !cos));
endmodule

// File: rtl/e1cas_status.sv
// Sticky status flags and interrupt combine. The shared bit shows either
// change of state or loss of transmit clock, per the mode bit.
// Assumes status_rd is a single-cycle pulse; a set in that cycle wins.
module e1cas_status
    import e1cas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  commit,
    input  logic  cos,
    input  logic  tx_clk_lost,
    input  logic  status_rd,
    input  ctrl_t ctrl,
    output logic  nd_flag,
    output logic  shared_bit,
    output logic  irq
);
    logic cos_flag;
    logic lotc_flag;

    // Set-dominant sticky flags, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nd_flag   <= 1'b0;
            cos_flag  <= 1'b0;
            lotc_flag <= 1'b0;
        end else begin
            nd_flag   <= commit      | (nd_flag   & ~status_rd);
            cos_flag  <= cos         | (cos_flag  & ~status_rd);
            lotc_flag <= tx_clk_lost | (lotc_flag & ~status_rd);
        end
    end

    // Mode-selected shared bit and enabled-OR interrupt.
    assign shared_bit = ctrl.cos_mode ? cos_flag : lotc_flag;
    assign irq        = (nd_flag & ctrl.nd_en) | (shared_bit & ctrl.sh_en);

    p_nd_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> nd_flag);
    p_nd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !commit) |=> !nd_flag);
    p_lotc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clk_lost && !ctrl.cos_mode) |=> (shared_bit || ctrl.cos_mode));
endmodule

// File: rtl/e1cas_regs.sv
// Host register port: signaling bank at 0..15, status at 16, control at 17.
// Read data is registered; a status read pulses status_rd for flag clearing.
module e1cas_regs
    import e1cas_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_rd,
    input  logic                          host_wr,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [CTRL_W-1:0]             host_wdata,
    input  logic [MF_LEN-1:0][BYTE_W-1:0] bank,
    input  logic                          nd_flag,
    input  logic                          shared_bit,
    output ctrl_t                         ctrl,
    output logic                          status_rd,
    output logic [BYTE_W-1:0]             host_rdata
);
    logic [BYTE_W-1:0] rd_mux;

    assign status_rd = host_rd && (host_addr == ADDR_W'(ADDR_STATUS));

    // Address decode for reads.
    always_comb begin
        rd_mux = '0;
        if (host_addr < ADDR_W'(MF_LEN))
            rd_mux = bank[host_addr[FRAME_W-1:0]];
        else if (host_addr == ADDR_W'(ADDR_STATUS))
            rd_mux = {{(BYTE_W-2){1'b0}}, shared_bit, nd_flag};
        else if (host_addr == ADDR_W'(ADDR_CTRL))
            rd_mux = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
    end

    // Control register write and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            host_rdata <= '0;
        end else begin
            if (host_wr && host_addr == ADDR_W'(ADDR_CTRL))
                ctrl <= ctrl_t'(host_wdata);
            if (host_rd)
                host_rdata <= rd_mux;
        end
    end

    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(ctrl));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr > ADDR_W'(ADDR_CTRL)) |=> (host_rdata == '0));
endmodule

// File: rtl/e1_cas_extract.sv
// Top of the E1 receive CAS signaling extractor: collector, status and
// host register port. Assumes an aligned framer upstream.
module e1_cas_extract
    import e1cas_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic [SLOT_W-1:0]     rx_slot,
    input  logic [FRAME_W-1:0]    rx_frame,
    input  logic                  tx_clk_lost,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [CTRL_W-1:0]     host_wdata,
    output logic [BYTE_W-1:0]     host_rdata,
    output logic                  irq
);
    logic [MF_LEN-1:0][BYTE_W-1:0] bank;
    logic  commit;
    logic  cos;
    logic  nd_flag;
    logic  shared_bit;
    logic  status_rd;
    ctrl_t ctrl;

    e1cas_collect u_collect (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_slot(rx_slot), .rx_frame(rx_frame), .bank(bank),
        .commit(commit), .cos(cos)
    );

    e1cas_status u_status (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cos(cos),
        .tx_clk_lost(tx_clk_lost), .status_rd(status_rd), .ctrl(ctrl),
        .nd_flag(nd_flag), .shared_bit(shared_bit), .irq(irq)
    );

    e1cas_regs u_regs (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .bank(bank),
        .nd_flag(nd_flag), .shared_bit(shared_bit), .ctrl(ctrl),
        .status_rd(status_rd), .host_rdata(host_rdata)
    );

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.nd_en && !ctrl.sh_en) |-> !irq);
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (host_rdata == '0 && !irq));
endmodule

// File: tb/e1_cas_extract_test.sv
module e1_cas_extract_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [4:0] rx_slot = '0;
    logic [3:0] rx_frame = '0;
    logic       tx_clk_lost = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [4:0] host_addr = '0;
    logic [2:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int nvec = 0;
    int nerr = 0;
    logic [7:0] mf [16];
    logic [7:0] exp_bank [16];

    e1_cas_extract uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_slot(rx_slot), .rx_frame(rx_frame), .tx_clk_lost(tx_clk_lost),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic host_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); host_rd = 1'b1; host_addr = a;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic host_write(input logic [4:0] a, input logic [2:0] v);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk); host_wr = 1'b0;
    endtask

    // Stream frames first..last; non-16 slots carry junk bytes.
    task automatic feed(input int first, input int last);
        for (int f = first; f <= last; f++) begin
            for (int s = 0; s < 32; s++) begin
                @(negedge clk);
                rx_valid = 1'b1; rx_slot = 5'(s); rx_frame = 4'(f);
                rx_byte  = (s == 16) ? mf[f] : 8'(s * 29 + f * 7 + 1);
            end
        end
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic commit_expect();
        for (int i = 0; i < 16; i++) exp_bank[i] = mf[i];
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        host_read(5'd16, d); check("R9 status after reset", d, 8'h00);
        host_read(5'd17, d); check("R9 ctrl after reset", d, 8'h00);
        host_read(5'd5, d);  check("R9 bank after reset", d, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        host_write(5'd17, 3'b111);
        host_read(5'd17, d); check("R10 ctrl readback", d, 8'h07);
        host_read(5'd20, d); check("R10 unmapped read", d, 8'h00);
    endtask

    task automatic t_first_mf();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) mf[i] = (i == 0) ? 8'h0B : 8'(i * 17 + 3);
        feed(0, 15); commit_expect();
        check("R8 irq with new data", {7'd0, irq}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            host_read(5'(i), d);
            check($sformatf("R1 R2 sig reg %0d", i), d, exp_bank[i]);
        end
        host_read(5'd16, d); check("R4 R6 status after first commit", d, 8'h01);
        host_read(5'd16, d); check("R4 status cleared by read", d, 8'h00);
        check("R8 irq after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_partial_and_frame0();
        logic [7:0] d;
        mf[0] = 8'h0F; mf[3] = 8'hC4; mf[3] = mf[3];
        mf[3] = exp_bank[3];
        mf[4] = exp_bank[4];
        feed(0, 8);
        host_read(5'd0, d); check("R3 reg0 stable mid multiframe", d, exp_bank[0]);
        host_read(5'd16, d); check("R3 no new data mid multiframe", d, 8'h00);
        feed(9, 15); commit_expect();
        host_read(5'd0, d); check("R2 reg0 updated", d, 8'h0F);
        host_read(5'd16, d); check("R5 frame0-only change ignored", d, 8'h01);
    endtask

    task automatic t_channel_change();
        logic [7:0] d;
        mf[7] = mf[7] ^ 8'h80;
        feed(0, 15); commit_expect();
        host_read(5'd7, d); check("R2 reg7 new value", d, exp_bank[7]);
        host_read(5'd16, d); check("R5 change of state", d, 8'h03);
        host_read(5'd16, d); check("R5 cos cleared", d, 8'h00);
    endtask

    task automatic t_lotc();
        logic [7:0] d;
        host_write(5'd17, 3'b110);
        check("R7 idle irq", {7'd0, irq}, 8'h00);
        @(negedge clk); tx_clk_lost = 1'b1;
        @(negedge clk); tx_clk_lost = 1'b0;
        check("R8 irq on clock loss", {7'd0, irq}, 8'h01);
        host_read(5'd16, d); check("R7 clock loss bit", d, 8'h02);
        host_read(5'd16, d); check("R7 clock loss cleared", d, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        host_write(5'd17, 3'b000);
        feed(0, 15);
        check("R8 masked irq", {7'd0, irq}, 8'h00);
        host_write(5'd17, 3'b010);
        check("R8 new-data enable irq", {7'd0, irq}, 8'h01);
        host_read(5'd16, d); check("R4 flag set while masked", d, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_first_mf();
        t_partial_and_frame0();
        t_channel_change();
        t_lotc();
        t_masked();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule